// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps wall-clock time and calendar date as packed BCD and presents them through an eight-byte window on a simple synchronous byte bus. An internal divider produces one count pulse every `TICK_CYCLES` clocks. Each pulse advances the time fields from seconds up to century, applying the calendar rules. A few control and status bits sit in the spare high bits of the time bytes.

Software gets a consistent reading by setting a freeze bit. This captures a snapshot that reads return while the live counters keep running. To set the time, software raises a hold bit and loads the fields into staging registers. It then drops the hold bit, and every staged field lands in the live counters in a single cycle. A stop bit halts counting. The bus can also read a battery-status input and read or write a frequency-test flag.

The hold path is a three-state machine:
- `HS_LIVE` moves to `HS_STAGE` when a byte-0 write has bit 7 set. On that edge the live time is captured into staging.
- `HS_STAGE` moves to `HS_COMMIT` when a byte-0 write has bit 7 clear.
- `HS_COMMIT` always returns to `HS_LIVE`. In this state the staging registers are loaded into the counters and the tick divider restarts.

Top module: `rtc_bcd_regfile`

## Requirements
- R1: After reset, the time is century 0x20, year 0x00, month 0x01, day of month 0x01, day of week 0x01, and 00:00:00. The stop bit is 1, and the hold, freeze and test flags are 0.
- R2: A read with `rd_en` high registers the addressed byte into `rd_data` on that clock edge. The byte layouts are:
  - Byte 0: {hold, freeze, century[5:0]}.
  - Byte 1: {stop, seconds[6:0]}.
  - Byte 2: {0, minutes[6:0]}.
  - Byte 3: {00, hours[5:0]}.
  - Byte 4: {batt_good, test, 000, weekday[2:0]}.
  - Byte 5: {00, mday[5:0]}.
  - Byte 6: {000, month[4:0]}.
  - Byte 7: year[7:0].
- R3: While the stop bit (byte 1, bit 7) is 1, no time field changes. A write to byte 1 always updates the stop bit.
- R4: While the clock is running, the time advances by one second on every `TICK_CYCLES`-th clock.
- R5: Seconds and minutes wrap from 59 to 00 with a carry. Hours wrap from 23 to 00 and carry into both day fields.
- R6: Day of week counts 1 to 7 and wraps from 7 to 1.
- R7: Day of month wraps to 01 after the last day of the month, and the month advances. Months 04, 06, 09 and 11 have 30 days; the others have 31 except February. Month wraps from 12 to 01 and advances the year.
- R8: February has 29 days when the year byte, read as a number, is divisible by 4, and 28 otherwise.
- R9: Year wraps from 99 to 00 and advances the century. Century wraps from 39 to 00.
- R10: Setting the freeze bit (byte 0, bit 6) captures the time fields. Reads then return the captured values until the bit is cleared, while counting continues.
- R11: Setting the hold bit (byte 0, bit 7) copies the live time into staging. Writes made while holding go only to staging, and reads keep showing the live or frozen time. Outside hold, writes to the time bits of any byte have no effect.
- R12: On the clock edge after the write that clears hold, all staged fields become the live time together. The divider restarts, so the next second falls `TICK_CYCLES` clocks after that edge.
- R13: Byte 4, bit 7 reads `batt_good`. Byte 4, bit 6 is a test flag that software can write and read back at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Byte offset in the window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte |
| batt_good | input | 1 | Battery status, 1 means good |

## Verification
Embedded properties check the following on every cycle:
- A stopped clock holds still.
- The seconds step by exactly one per pulse.
- Tick pulses never come back to back.
- Hold entry copies the live time into staging.
- The commit cycle loads staging.
- A held freeze keeps the snapshot unchanged.

Only the bench scenarios can show the calendar outcomes: the rollover from 23:59:59 on 31 December of year 99 into a new century, the leap and common February ends, and the 30-day months. The same applies to byte composition, the exact timing of the first second after a commit, and the ignoring of time writes outside hold.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

    typedef struct packed {
        logic [5:0] cen;
        logic [7:0] yr;
        logic [4:0] mon;
        logic [5:0] dom;
        logic [2:0] dow;
        logic [5:0] hr;
        logic [6:0] min;
        logic [6:0] sec;
    } rtc_time_t;

    typedef enum logic [1:0] {
        HS_LIVE   = 2'd0,
        HS_STAGE  = 2'd1,
        HS_COMMIT = 2'd2
    } hold_state_e;

    localparam logic [2:0] OFS_CEN = 3'd0;
    localparam logic [2:0] OFS_SEC = 3'd1;
    localparam logic [2:0] OFS_MIN = 3'd2;
    localparam logic [2:0] OFS_HR  = 3'd3;
    localparam logic [2:0] OFS_DOW = 3'd4;
    localparam logic [2:0] OFS_DOM = 3'd5;
    localparam logic [2:0] OFS_MON = 3'd6;

    localparam rtc_time_t RESET_TIME = '{cen: 6'h20, yr: 8'h00, mon: 5'h01,
                                         dom: 6'h01, dow: 3'd1, hr: 6'h00,
                                         min: 7'h00, sec: 7'h00};

    // Add one to a two-digit BCD byte.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last day of a BCD month. A BCD value is divisible by 4 when its
    // tens digit is even and its units are 0/4/8, or the tens digit is odd
    // and its units are 2/6.
    function automatic logic [5:0] month_last(input logic [4:0] mon,
                                              input logic [7:0] yr);
        logic leap;
        leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                     : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
        case (mon)
            5'h02:                      return leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int TICK_CYCLES = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    p_clr_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_bcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t now
);
    rtc_time_t nxt;

    always_comb begin
        nxt = now;
        if (load) begin
            nxt = load_val;
        end else if (adv) begin
            if (now.sec == 7'h59) begin
                nxt.sec = '0;
                if (now.min == 7'h59) begin
                    nxt.min = '0;
                    if (now.hr == 6'h23) begin
                        nxt.hr  = '0;
                        nxt.dow = (now.dow == 3'd7) ? 3'd1 : now.dow + 3'd1;
                        if (now.dom == month_last(now.mon, now.yr)) begin
                            nxt.dom = 6'h01;
                            if (now.mon == 5'h12) begin
                                nxt.mon = 5'h01;
                                if (now.yr == 8'h99) begin
                                    nxt.yr  = '0;
                                    nxt.cen = (now.cen == 6'h39) ? 6'h00
                                              : 6'(bcd_inc({2'b00, now.cen}));
                                end else begin
                                    nxt.yr = bcd_inc(now.yr);
                                end
                            end else begin
                                nxt.mon = 5'(bcd_inc({3'b000, now.mon}));
                            end
                        end else begin
                            nxt.dom = 6'(bcd_inc({2'b00, now.dom}));
                        end
                    end else begin
                        nxt.hr = 6'(bcd_inc({2'b00, now.hr}));
                    end
                end else begin
                    nxt.min = 7'(bcd_inc({1'b0, now.min}));
                end
            end else begin
                nxt.sec = 7'(bcd_inc({1'b0, now.sec}));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            now <= RESET_TIME;
        else
            now <= nxt;
    end

    p_idle_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(now));

    p_sec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && now.sec[3:0] < 4'd9) |=> (now.sec == $past(now.sec) + 7'd1));

endmodule

// File: rtl/rtc_bcd_regfile.sv
module rtc_bcd_regfile
    import rtc_bcd_pkg::*;
#(
    parameter int TICK_CYCLES = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    input  logic       batt_good
);
    hold_state_e state, state_nxt;
    logic        hold_flag, commit;
    logic        freeze_q, stop_q, test_q;
    logic        tick, wr_ctl;
    rtc_time_t   live, stg, snap, view;

    assign wr_ctl = wr_en && (addr == OFS_CEN);

    rtc_tick_div #(.TICK_CYCLES(TICK_CYCLES)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (commit),
        .tick (tick)
    );

    rtc_time_chain u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (tick && !stop_q),
        .load    (commit),
        .load_val(stg),
        .now     (live)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= HS_LIVE;
        else
            state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            HS_LIVE:   if (wr_ctl && wr_data[7])  state_nxt = HS_STAGE;
            HS_STAGE:  if (wr_ctl && !wr_data[7]) state_nxt = HS_COMMIT;
            HS_COMMIT: state_nxt = HS_LIVE;
            default:   state_nxt = HS_LIVE;
        endcase
    end

    // State outputs
    always_comb begin
        hold_flag = (state == HS_STAGE);
        commit    = (state == HS_COMMIT);
    end

    // Staging registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= RESET_TIME;
        end else if (state == HS_LIVE && wr_ctl && wr_data[7]) begin
            stg <= live;
        end else if (hold_flag && wr_en) begin
            case (addr)
                OFS_CEN: stg.cen <= wr_data[5:0];
                OFS_SEC: stg.sec <= wr_data[6:0];
                OFS_MIN: stg.min <= wr_data[6:0];
                OFS_HR:  stg.hr  <= wr_data[5:0];
                OFS_DOW: stg.dow <= wr_data[2:0];
                OFS_DOM: stg.dom <= wr_data[5:0];
                OFS_MON: stg.mon <= wr_data[4:0];
                default: stg.yr  <= wr_data;
            endcase
        end
    end

    // Control flags and the freeze snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freeze_q <= 1'b0;
            stop_q   <= 1'b1;
            test_q   <= 1'b0;
            snap     <= RESET_TIME;
        end else if (wr_en) begin
            if (addr == OFS_CEN) begin
                if (!freeze_q && wr_data[6])
                    snap <= live;
                freeze_q <= wr_data[6];
            end
            if (addr == OFS_SEC) stop_q <= wr_data[7];
            if (addr == OFS_DOW) test_q <= wr_data[6];
        end
    end

    assign view = freeze_q ? snap : live;

    // Registered read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (addr)
                OFS_CEN: rd_data <= {hold_flag, freeze_q, view.cen};
                OFS_SEC: rd_data <= {stop_q, view.sec};
                OFS_MIN: rd_data <= {1'b0, view.min};
                OFS_HR:  rd_data <= {2'b00, view.hr};
                OFS_DOW: rd_data <= {batt_good, test_q, 3'b000, view.dow};
                OFS_DOM: rd_data <= {2'b00, view.dom};
                OFS_MON: rd_data <= {3'b000, view.mon};
                default: rd_data <= view.yr;
            endcase
        end
    end

    p_commit_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (live == $past(stg)));

    p_hold_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_LIVE && wr_ctl && wr_data[7]) |=> (hold_flag && stg == $past(live)));

    p_freeze_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_q && $past(freeze_q)) |-> $stable(snap));

endmodule

// File: tb/rtc_bcd_regfile_test.sv
module rtc_bcd_regfile_test;
    localparam int TCK = 4;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       batt_good = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    rtc_bcd_regfile #(.TICK_CYCLES(TCK)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .batt_good(batt_good)
    );

    // ---------------- reference model ----------------
    logic [7:0] m_t[8], m_stg[8], m_snap[8], o[8], n[8], vw[8];
    logic       m_frz, m_osc, m_ft;
    int         m_state, m_div;
    logic [7:0] m_rd;

    function automatic int b2i(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction
    function automatic logic [7:0] i2b(input int x);
        return {4'(x / 10), 4'(x % 10)};
    endfunction
    function automatic int mlen(input int mo, input int y);
        case (mo)
            2: return (y % 4 == 0) ? 29 : 28;
            4, 6, 9, 11: return 30;
            default: return 31;
        endcase
    endfunction
    function automatic logic [7:0] fmask(input int a);
        case (a)
            0, 3, 5: return 8'h3F;
            1, 2:    return 8'h7F;
            4:       return 8'h07;
            6:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_t[0] = 8'h20; m_t[1] = 8'h00; m_t[2] = 8'h00; m_t[3] = 8'h00;
            m_t[4] = 8'h01; m_t[5] = 8'h01; m_t[6] = 8'h01; m_t[7] = 8'h00;
            m_stg = m_t; m_snap = m_t;
            m_frz = 1'b0; m_osc = 1'b1; m_ft = 1'b0;
            m_state = 0; m_div = 0; m_rd = 8'h00;
        end else begin
            bit tick;
            o = m_t; n = o;
            tick = (m_div == TCK - 1);
            vw = m_frz ? m_snap : o;
            if (rd_en) begin
                case (addr)
                    3'd0: m_rd = {(m_state == 1), m_frz, vw[0][5:0]};
                    3'd1: m_rd = {m_osc, vw[1][6:0]};
                    3'd4: m_rd = {batt_good, m_ft, 3'b000, vw[4][2:0]};
                    default: m_rd = vw[addr];
                endcase
            end
            if (m_state == 2) begin
                n = m_stg;
            end else if (tick && !m_osc) begin
                int s, mi, h, dw, dm, mo, y, c;
                c = b2i(o[0]); s = b2i(o[1]); mi = b2i(o[2]); h = b2i(o[3]);
                dw = b2i(o[4]); dm = b2i(o[5]); mo = b2i(o[6]); y = b2i(o[7]);
                s++;
                if (s > 59) begin
                    s = 0; mi++;
                    if (mi > 59) begin
                        mi = 0; h++;
                        if (h > 23) begin
                            h = 0; dw = (dw >= 7) ? 1 : dw + 1; dm++;
                            if (dm > mlen(mo, y)) begin
                                dm = 1; mo++;
                                if (mo > 12) begin
                                    mo = 1; y++;
                                    if (y > 99) begin
                                        y = 0; c = (c >= 39) ? 0 : c + 1;
                                    end
                                end
                            end
                        end
                    end
                end
                n[0] = i2b(c); n[1] = i2b(s); n[2] = i2b(mi); n[3] = i2b(h);
                n[4] = i2b(dw); n[5] = i2b(dm); n[6] = i2b(mo); n[7] = i2b(y);
            end
            m_div = (m_state == 2 || tick) ? 0 : m_div + 1;
            if (wr_en) begin
                if (addr == 3'd0) begin
                    if (!m_frz && wr_data[6]) m_snap = o;
                    m_frz = wr_data[6];
                end
                if (addr == 3'd1) m_osc = wr_data[7];
                if (addr == 3'd4) m_ft = wr_data[6];
            end
            case (m_state)
                0: if (wr_en && addr == 3'd0 && wr_data[7]) begin
                       m_stg = o; m_state = 1;
                   end
                1: if (wr_en) begin
                       m_stg[addr] = wr_data & fmask(int'(addr));
                       if (addr == 3'd0 && !wr_data[7]) m_state = 2;
                   end
                default: m_state = 0;
            endcase
            m_t = n;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) check(rd_data === m_rd, "R2 model", rd_data, m_rd);
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_get(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; v = rd_data;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] v;
        rd_get(a, v);
        check(v === exp, tag, v, exp);
    endtask

    // Load a time under hold, commit it, then freeze right after the first second.
    task automatic set_and_freeze(input logic [7:0] c, input logic [7:0] y, input logic [7:0] mo,
                                  input logic [7:0] dm, input logic [7:0] dw, input logic [7:0] h,
                                  input logic [7:0] mi, input logic [7:0] s);
        wr(3'd0, 8'h80);
        wr(3'd1, s); wr(3'd2, mi); wr(3'd3, h); wr(3'd4, dw);
        wr(3'd5, dm); wr(3'd6, mo); wr(3'd7, y);
        wr(3'd0, {2'b00, c[5:0]});
        repeat (5) @(negedge clk);
        wr(3'd0, 8'h40);
    endtask

    initial begin
        wait (cyc >= WATCHDOG);
        errors++; checks++;
        $display("FAIL watchdog R1..: actual cycles=%0d expected < %0d", cyc, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd_chk(3'd0, 8'h20, "R1 century");
        rd_chk(3'd1, 8'h80, "R1 stop+sec");
        rd_chk(3'd3, 8'h00, "R1 hours");
        rd_chk(3'd4, 8'h81, "R1 weekday");
        rd_chk(3'd6, 8'h01, "R1 month");

        // R3 stopped clock holds still
        repeat (20) @(negedge clk);
        rd_chk(3'd1, 8'h80, "R3 stopped");

        // R5 R6 R7 R9 full rollover, R4 R12 exact first second
        set_and_freeze(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
        rd_chk(3'd0, 8'h61, "R9 century up, freeze set");
        rd_chk(3'd1, 8'h00, "R4 R12 R5 seconds");
        rd_chk(3'd2, 8'h00, "R5 minutes");
        rd_chk(3'd3, 8'h00, "R5 hours");
        rd_chk(3'd4, 8'h81, "R6 weekday wrap");
        rd_chk(3'd5, 8'h01, "R7 mday");
        rd_chk(3'd6, 8'h01, "R7 month wrap");
        rd_chk(3'd7, 8'h00, "R9 year wrap");

        // R10 snapshot stays while counting continues
        repeat (12) @(negedge clk);
        rd_chk(3'd1, 8'h00, "R10 frozen");
        wr(3'd0, 8'h00);
        rd_get(3'd1, a);
        check(a != 8'h00, "R10 live resumed", a, 8'h00);

        // R11 time writes outside hold ignored
        wr(3'd7, 8'h55);
        rd_chk(3'd7, 8'h00, "R11 year write ignored");

        // R13 battery and test flag
        batt_good = 1'b0;
        rd_chk(3'd4, 8'h01, "R13 battery low");
        wr(3'd4, 8'h46);
        rd_chk(3'd4, 8'h41, "R13 test flag, weekday kept");
        batt_good = 1'b1;
        rd_chk(3'd4, 8'hC1, "R13 battery good");

        // R3 stop bit halts
        wr(3'd1, 8'h80);
        rd_get(3'd1, a);
        repeat (20) @(negedge clk);
        rd_get(3'd1, b);
        check(b === a && b[7], "R3 halted", b, a);

        // R8 leap and common February
        set_and_freeze(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        rd_chk(3'd5, 8'h29, "R8 leap mday");
        rd_chk(3'd6, 8'h02, "R8 leap month");
        rd_chk(3'd4, 8'h84, "R6 weekday step");
        wr(3'd0, 8'h00);
        set_and_freeze(8'h20, 8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        rd_chk(3'd5, 8'h01, "R8 common mday");
        rd_chk(3'd6, 8'h03, "R8 common month");
        wr(3'd0, 8'h00);

        // R7 thirty-day month
        set_and_freeze(8'h20, 8'h24, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        rd_chk(3'd5, 8'h01, "R7 30-day mday");
        rd_chk(3'd6, 8'h05, "R7 30-day month");
        wr(3'd0, 8'h00);

        // R11 staged write invisible until R12 commit
        wr(3'd0, 8'h80);
        rd_chk(3'd0, 8'hA0, "R11 hold flag");
        wr(3'd2, 8'h33);
        rd_chk(3'd2, 8'h00, "R11 staged not visible");
        wr(3'd0, 8'h20);
        @(negedge clk);
        rd_chk(3'd2, 8'h33, "R12 committed minutes");

        repeat (10) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule